// File: doc/BRIEF.md
# Linked-Packet Memory-to-Device DMA Walker

This block moves data from memory to a device by following a chain of packets. Every packet starts with one header word that carries the number of payload words and the address of the following header. The walker reads a header over a single-outstanding memory read port, fetches the payload words that follow it in ascending word order, and offers each word on a valid/ready stream towards the device. The chain ends when a next-packet address has its top address bit set.

The device holds a request line high while it can accept packets. The walker only checks that line, and its time budget, between packets. A packet whose header has been read is always streamed in full. Each header read and each payload word costs one tick. Once the ticks spent reach the configured slice limit, the walker halts for a configured number of cycles, clears its tick count and then carries on from the saved header pointer. The bus stays free for other masters during the halt. If the request line is low at a packet boundary, the walker parks with the pointer saved and resumes when the request returns.

Top module: `ll_chain_dma`

## Requirements
- R1: After reset, busy_o, done_o, halted_o, mem_req_o and dev_valid_o are all low.
- R2: A go_i pulse while idle loads base_addr_i into ptr_o and raises busy_o. A go_i pulse while busy is ignored, and the walk in progress continues unchanged.
- R3: A header is read at ptr_o. Its payload count is header bits [31:24] and its next-packet address is header bits [23:0]. Read data is taken from mem_rdata_i in the cycle after mem_req_o is high.
- R4: Payload words are read from the header address plus 4, then plus 8, and so on. They appear on dev_data_o in that order. Once dev_valid_o is high it stays high, with stable data, until dev_ready_i is high.
- R5: A header with a count of 0 produces no stream word, and the walk moves straight on to the next address.
- R6: When ptr_o has bit 23 set at a packet boundary, busy_o falls, done_o is high for exactly one cycle, and ptr_o keeps that terminating address. A base address that already has bit 23 set completes without any memory read.
- R7: At each packet boundary, if the ticks spent (1 per header plus 1 per payload word since the walk started or since the last halt) are at least slice_max_i, the walker halts and the tick count restarts from zero.
- R8: A halt keeps halted_o high for hold_ticks_i cycles, or for 1 cycle when hold_ticks_i is 0. During the halt there is no memory read and no stream word. Afterwards the walk resumes at ptr_o.
- R9: If dev_req_i is low at a packet boundary, no header is read, busy_o stays high, done_o stays low, and ptr_o holds the next header address. A packet already in progress completes first. The walk resumes when dev_req_i returns high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| go_i | input | 1 | Start a walk (sampled while idle) |
| base_addr_i | input | 24 | First header address |
| slice_max_i | input | 16 | Tick budget per slice |
| hold_ticks_i | input | 16 | Halt length in cycles |
| dev_req_i | input | 1 | Device request |
| mem_req_o | output | 1 | Memory read strobe |
| mem_addr_o | output | 24 | Memory read byte address |
| mem_rdata_i | input | 32 | Read data, valid one cycle after the strobe |
| dev_valid_o | output | 1 | Stream word valid |
| dev_data_o | output | 32 | Stream word |
| dev_ready_i | input | 1 | Device accepts the word |
| busy_o | output | 1 | Walk in progress |
| halted_o | output | 1 | Slice halt in progress |
| done_o | output | 1 | One-cycle completion pulse |
| ptr_o | output | 24 | Current or saved header pointer |

## Verification
The bench builds the walker with its default widths (24-bit addresses, 8-bit counts, 16-bit tick fields) against a 256-word memory model. It sweeps slice limits from 1 to 200, hold lengths from 0 to 3 and three packet-length patterns that include zero-length packets, which makes every possible halt position within a six-packet chain reachable. Halt counts and stream contents are derived arithmetically from the packet lengths. Separate runs drop the request before the start and in the middle of a packet, start at a terminator address, and re-pulse go_i during a walk.

// File: rtl/ll_dma_pkg.sv
`timescale 1ns/1ps
package ll_dma_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CHECK,
    ST_HOLD,
    ST_HDR_RD,
    ST_HDR_WT,
    ST_PAY_RD,
    ST_PAY_WT,
    ST_PAY_OUT
  } walk_state_e;
endpackage

// File: rtl/ll_hdr_split.sv
`timescale 1ns/1ps
module ll_hdr_split #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 24,
  parameter int CNT_W  = 8
) (
  input  logic [DATA_W-1:0] hdr_i,
  output logic [CNT_W-1:0]  cnt_o,
  output logic [ADDR_W-1:0] next_o
);
  assign cnt_o  = hdr_i[DATA_W-1 -: CNT_W];
  assign next_o = hdr_i[ADDR_W-1:0];
endmodule

// File: rtl/ll_tick_budget.sv
`timescale 1ns/1ps
module ll_tick_budget #(
  parameter int TICK_W = 16,
  parameter int CNT_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              inc_i,
  input  logic [TICK_W-1:0] limit_i,
  output logic              spent_o
);
  // headroom for one full packet past the limit
  localparam int USED_W = ((TICK_W > CNT_W) ? TICK_W : CNT_W) + 1;

  logic [USED_W-1:0] used_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     used_q <= '0;
    else if (clr_i)  used_q <= '0;
    else if (inc_i)  used_q <= used_q + USED_W'(1);
  end

  assign spent_o = used_q >= USED_W'(limit_i);

  // R7: a cleared budget starts from zero
  a_r7_budget_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (used_q == '0));
endmodule

// File: rtl/ll_holdoff.sv
`timescale 1ns/1ps
module ll_holdoff #(
  parameter int TICK_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [TICK_W-1:0] len_i,
  input  logic              run_i,
  output logic              expire_o
);
  logic [TICK_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  cnt_q <= '0;
    else if (load_i)              cnt_q <= len_i;
    else if (run_i && !expire_o)  cnt_q <= cnt_q - TICK_W'(1);
  end

  // a zero length still costs one cycle
  assign expire_o = cnt_q <= TICK_W'(1);

  // R8: hold length captured on entry
  a_r8_hold_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (cnt_q == $past(len_i)));
endmodule

// File: rtl/ll_chain_dma.sv
`timescale 1ns/1ps
module ll_chain_dma
  import ll_dma_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 8,
  parameter int TICK_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              go_i,
  input  logic [ADDR_W-1:0] base_addr_i,
  input  logic [TICK_W-1:0] slice_max_i,
  input  logic [TICK_W-1:0] hold_ticks_i,
  input  logic              dev_req_i,
  output logic              mem_req_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic              dev_valid_o,
  output logic [DATA_W-1:0] dev_data_o,
  input  logic              dev_ready_i,
  output logic              busy_o,
  output logic              halted_o,
  output logic              done_o,
  output logic [ADDR_W-1:0] ptr_o
);
  localparam logic [ADDR_W-1:0] WORD_STEP = ADDR_W'(DATA_W / 8);

  walk_state_e       state_q;
  logic [ADDR_W-1:0] ptr_q, next_q, waddr_q;
  logic [CNT_W-1:0]  left_q;
  logic [DATA_W-1:0] data_q;
  logic              done_q;

  logic [CNT_W-1:0]  hdr_cnt;
  logic [ADDR_W-1:0] hdr_next;
  logic              spent, hold_expire;
  logic              end_hit, start_walk, enter_hold, tick_inc;

  assign end_hit    = ptr_q[ADDR_W-1];
  assign start_walk = (state_q == ST_IDLE) && go_i;
  assign enter_hold = (state_q == ST_CHECK) && !end_hit && dev_req_i && spent;
  assign tick_inc   = (state_q == ST_HDR_WT) ||
                      ((state_q == ST_PAY_OUT) && dev_ready_i);

  ll_hdr_split #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_split (
    .hdr_i  (mem_rdata_i),
    .cnt_o  (hdr_cnt),
    .next_o (hdr_next)
  );

  ll_tick_budget #(.TICK_W(TICK_W), .CNT_W(CNT_W)) u_budget (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (start_walk || enter_hold),
    .inc_i   (tick_inc),
    .limit_i (slice_max_i),
    .spent_o (spent)
  );

  ll_holdoff #(.TICK_W(TICK_W)) u_hold (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (enter_hold),
    .len_i    (hold_ticks_i),
    .run_i    (state_q == ST_HOLD),
    .expire_o (hold_expire)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      ptr_q   <= '0;
      next_q  <= '0;
      waddr_q <= '0;
      left_q  <= '0;
      data_q  <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (go_i) begin
          ptr_q   <= base_addr_i;
          state_q <= ST_CHECK;
        end
        ST_CHECK: begin
          // end marker wins over request and budget
          if (end_hit) begin
            done_q  <= 1'b1;
            state_q <= ST_IDLE;
          end else if (dev_req_i) begin
            state_q <= spent ? ST_HOLD : ST_HDR_RD;
          end
        end
        ST_HOLD:   if (hold_expire) state_q <= ST_CHECK;
        ST_HDR_RD: state_q <= ST_HDR_WT;
        ST_HDR_WT: begin
          next_q  <= hdr_next;
          left_q  <= hdr_cnt;
          waddr_q <= ptr_q + WORD_STEP;
          if (hdr_cnt == '0) begin
            ptr_q   <= hdr_next;
            state_q <= ST_CHECK;
          end else begin
            state_q <= ST_PAY_RD;
          end
        end
        ST_PAY_RD: state_q <= ST_PAY_WT;
        ST_PAY_WT: begin
          data_q  <= mem_rdata_i;
          state_q <= ST_PAY_OUT;
        end
        ST_PAY_OUT: if (dev_ready_i) begin
          waddr_q <= waddr_q + WORD_STEP;
          left_q  <= left_q - CNT_W'(1);
          if (left_q == CNT_W'(1)) begin
            ptr_q   <= next_q;
            state_q <= ST_CHECK;
          end else begin
            state_q <= ST_PAY_RD;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign mem_req_o   = (state_q == ST_HDR_RD) || (state_q == ST_PAY_RD);
  assign mem_addr_o  = (state_q == ST_PAY_RD) ? waddr_q : ptr_q;
  assign dev_valid_o = (state_q == ST_PAY_OUT);
  assign dev_data_o  = data_q;
  assign busy_o      = (state_q != ST_IDLE);
  assign halted_o    = (state_q == ST_HOLD);
  assign done_o      = done_q;
  assign ptr_o       = ptr_q;

  // R4: offered word held until accepted
  a_r4_valid_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dev_valid_o && !dev_ready_i) |=> (dev_valid_o && $stable(dev_data_o)));
  // R3: one activity at a time on the two interfaces
  a_r3_port_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mem_req_o && dev_valid_o));
  // R8: bus quiet while halted
  a_r8_quiet_halt: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halted_o |-> (!mem_req_o && !dev_valid_o));
  // R6: completion pulse only when idle
  a_r6_done_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!busy_o && $past(busy_o)));
  // R9: header read only after a request at the boundary
  a_r9_hdr_needs_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_HDR_RD) |-> $past(dev_req_i));
endmodule

// File: tb/tb_ll_chain_dma.sv
`timescale 1ns/1ps
module tb_ll_chain_dma;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 24;
  localparam int DATA_W = 32;
  localparam logic [ADDR_W-1:0] END_ADDR = 24'h801230;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              go = 1'b0;
  logic [ADDR_W-1:0] base_addr = '0;
  logic [15:0]       slice_max = 16'd100;
  logic [15:0]       hold_ticks = 16'd1;
  logic              req_drv = 1'b1;
  logic              dev_req;
  logic              mem_req;
  logic [ADDR_W-1:0] mem_addr;
  logic [DATA_W-1:0] mem_rdata = '0;
  logic              dev_valid;
  logic [DATA_W-1:0] dev_data;
  logic              dev_ready = 1'b1;
  logic              busy, halted, done;
  logic [ADDR_W-1:0] ptr;

  logic [DATA_W-1:0] mem [0:255];
  logic [DATA_W-1:0] exp_q [0:255];
  int exp_n = 0, exp_base = 0, exp_hlen = 1;
  int cnt_a [0:15];
  int chain_n = 0;
  bit ready_mode = 1'b0;
  bit drop_en = 1'b0;
  int drop_at = 0;

  // monitor-owned
  int exp_idx = 0, stream_err = 0, halt_runs = 0, halt_len_err = 0;
  int cur_hlen = 0, done_cnt = 0, memreq_cnt = 0;
  logic [7:0] lfsr = 8'h5A;

  int checks = 0, failures = 0;

  assign dev_req = req_drv && !(drop_en && (exp_idx >= drop_at));

  ll_chain_dma dut (
    .clk_i(clk), .rst_ni(rst_n), .go_i(go), .base_addr_i(base_addr),
    .slice_max_i(slice_max), .hold_ticks_i(hold_ticks), .dev_req_i(dev_req),
    .mem_req_o(mem_req), .mem_addr_o(mem_addr), .mem_rdata_i(mem_rdata),
    .dev_valid_o(dev_valid), .dev_data_o(dev_data), .dev_ready_i(dev_ready),
    .busy_o(busy), .halted_o(halted), .done_o(done), .ptr_o(ptr)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) if (mem_req) mem_rdata <= mem[mem_addr[9:2]];

  always @(negedge clk) begin
    lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    dev_ready = ready_mode ? lfsr[0] : 1'b1;
    if (dev_valid && dev_ready) begin
      if ((exp_idx - exp_base) >= exp_n || dev_data != exp_q[exp_idx - exp_base])
        stream_err++;
      exp_idx++;
    end
    if (halted) cur_hlen++;
    else if (cur_hlen > 0) begin
      halt_runs++;
      if (cur_hlen != exp_hlen) halt_len_err++;
      cur_hlen = 0;
    end
    if (done) done_cnt++;
    if (mem_req) memreq_cnt++;
  end

  initial begin
    repeat (190000) @(posedge clk);
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures + 1);
    $finish;
  end

  task automatic tick();
    @(posedge clk);
    #(CLK_PERIOD/4);
  endtask

  task automatic chk(bit ok, string what, longint act, longint expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s act=%0h exp=%0h", what, act, expv);
    end
  endtask

  function automatic int slot_addr(int i);
    return ((i * 5) % 16) * 64;
  endfunction

  task automatic build(int v, int n);
    chain_n = n;
    exp_n = 0;
    for (int i = 0; i < n; i++) begin
      int c;
      logic [ADDR_W-1:0] nxt;
      int w0;
      if (v == 0)      c = i % 6;
      else if (v == 1) c = (2 * i + 1) % 6;
      else if (v == 2) c = (i % 2) * 7;
      else             c = (i == 0) ? 2 : (i == 1) ? 3 : 1;
      cnt_a[i] = c;
      nxt = (i == n - 1) ? END_ADDR : ADDR_W'(slot_addr(i + 1));
      w0 = slot_addr(i) / 4;
      mem[w0] = {8'(c), nxt};
      for (int j = 0; j < c; j++) begin
        logic [DATA_W-1:0] w;
        w = 32'hD000_0000 + DATA_W'(v << 20) + DATA_W'(i << 8) + DATA_W'(j);
        mem[w0 + 1 + j] = w;
        exp_q[exp_n] = w;
        exp_n++;
      end
    end
  endtask

  function automatic int calc_halts(int slice);
    int used = 0;
    int h = 0;
    for (int i = 0; i < chain_n; i++) begin
      if (used >= slice) begin
        h++;
        used = 0;
      end
      used += 1 + cnt_a[i];
    end
    return h;
  endfunction

  task automatic pulse_go(logic [ADDR_W-1:0] b);
    base_addr = b;
    go = 1'b1;
    tick();
    go = 1'b0;
  endtask

  task automatic wait_done(int d0);
    for (int c = 0; c < 20000; c++) begin
      if (done_cnt != d0) break;
      tick();
    end
    repeat (3) tick();
  endtask

  task automatic run_walk(int slice, int hold, bit extra_go, string tag);
    int d0, h0, e0, s0;
    slice_max = 16'(slice);
    hold_ticks = 16'(hold);
    exp_hlen = (hold == 0) ? 1 : hold;
    exp_base = exp_idx;
    d0 = done_cnt; h0 = halt_runs; e0 = halt_len_err; s0 = stream_err;
    pulse_go(ADDR_W'(slot_addr(0)));
    if (extra_go) begin
      repeat (20) tick();
      pulse_go(24'h0003C0);
    end
    wait_done(d0);
    chk(done_cnt == d0 + 1, {"R6 single done pulse ", tag}, done_cnt - d0, 1);
    chk(busy == 1'b0, {"R6 busy clear ", tag}, busy, 0);
    chk(ptr == END_ADDR, {"R6 ptr at terminator ", tag}, ptr, END_ADDR);
    chk(exp_idx - exp_base == exp_n, {"R4 R5 word count ", tag}, exp_idx - exp_base, exp_n);
    chk(stream_err == s0, {"R3 R4 stream data ", tag}, stream_err - s0, 0);
    chk(halt_runs - h0 == calc_halts(slice), {"R7 halt count ", tag},
        halt_runs - h0, calc_halts(slice));
    chk(halt_len_err == e0, {"R8 halt length ", tag}, halt_len_err - e0, 0);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = '0;
    repeat (3) tick();
    // R1
    chk(!busy && !done && !halted && !mem_req && !dev_valid, "R1 reset outputs",
        {busy, done, halted, mem_req, dev_valid}, 0);
    rst_n = 1'b1;
    repeat (2) tick();
    chk(!busy && !done, "R1 idle after reset", {busy, done}, 0);

    // R3 R4 R5 R7 R8: sweep slices, holds, length patterns, stall patterns
    for (int v = 0; v < 3; v++) begin
      for (int k = 0; k < 6; k++) begin
        int sl;
        sl = (k == 0) ? 1 : (k == 1) ? 2 : (k == 2) ? 3 : (k == 3) ? 5 : (k == 4) ? 8 : 200;
        build(v, 6);
        ready_mode = (v == 1);
        run_walk(sl, sl % 4, 1'b0, $sformatf("v%0d s%0d", v, sl));
      end
    end
    ready_mode = 1'b0;

    // R2: go while busy ignored
    build(0, 6);
    run_walk(200, 1, 1'b1, "R2 go while busy");

    // R6: base already terminator
    begin
      int d0, m0;
      d0 = done_cnt; m0 = memreq_cnt;
      pulse_go(24'h800040);
      repeat (5) tick();
      chk(done_cnt == d0 + 1, "R6 terminator base done", done_cnt - d0, 1);
      chk(memreq_cnt == m0, "R6 terminator base no read", memreq_cnt - m0, 0);
      chk(ptr == 24'h800040, "R6 terminator base ptr", ptr, 24'h800040);
      chk(!busy, "R6 terminator base idle", busy, 0);
    end

    // R9: request low before start
    begin
      int d0, m0;
      build(3, 3);
      slice_max = 16'd200; hold_ticks = 16'd1; exp_hlen = 1;
      exp_base = exp_idx;
      d0 = done_cnt; m0 = memreq_cnt;
      req_drv = 1'b0;
      pulse_go(24'h000000);
      repeat (20) tick();
      chk(memreq_cnt == m0, "R9 no read without request", memreq_cnt - m0, 0);
      chk(busy && done_cnt == d0, "R9 parked busy", {busy, 8'(done_cnt - d0)}, 9'h100);
      chk(ptr == 24'h000000, "R9 parked ptr", ptr, 0);
      req_drv = 1'b1;
      wait_done(d0);
      chk(exp_idx - exp_base == exp_n && done_cnt == d0 + 1, "R9 resume completes",
          exp_idx - exp_base, exp_n);
    end

    // R9: request drops inside packet 1
    begin
      int d0, s0;
      build(3, 3);
      exp_base = exp_idx;
      d0 = done_cnt; s0 = stream_err;
      drop_at = exp_idx + 3;
      drop_en = 1'b1;
      pulse_go(24'h000000);
      repeat (60) tick();
      chk(exp_idx - exp_base == 5, "R9 packet in flight completes", exp_idx - exp_base, 5);
      chk(ptr == ADDR_W'(slot_addr(2)), "R9 saved next pointer", ptr, slot_addr(2));
      chk(busy && !dev_valid && !mem_req, "R9 stopped between packets",
          {busy, dev_valid, mem_req}, 3'b100);
      chk(done_cnt == d0, "R9 no completion while parked", done_cnt - d0, 0);
      drop_en = 1'b0;
      wait_done(d0);
      chk(exp_idx - exp_base == exp_n && stream_err == s0, "R9 resume after drop",
          exp_idx - exp_base, exp_n);
      chk(done_cnt == d0 + 1, "R9 done after resume", done_cnt - d0, 1);
    end

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule